// File: doc/BRIEF.md
# Interval/PWM Timer with Double-Buffered Period Register

This block is an up-counting timer with two byte-wide compare registers that a CPU reaches through a small write-strobe register port. The first compare register, the duty threshold, is static. The CPU can change it only while the timer is stopped. The second compare register, the period, has two copies. One is a CPU-side buffer. The other is an active copy that the counter is compared against. The CPU can therefore retune the period while the timer runs, and the new value takes effect at a clean period boundary.

When the counter reaches the active period value, three things happen together. The counter restarts from zero, a one-cycle interrupt pulse is raised, and the buffered period is promoted into the active copy. The promotion is skipped if the CPU writes the period register in that same cycle. A mode input chooses one of three output behaviours: a square wave at the period rate, a PWM waveform, or a carrier waveform that toggles on both compare events.

A sticky flag tracks whether the period has been written since the last stop. If the timer is enabled in PWM or carrier mode without that fresh write, an error strobe is raised. All control pins are plain levels or strobes. The block has no streaming interface, so no back-pressure applies.

Top module: `tmrb_top`

## Requirements
- R1: After reset, the counter, both compare registers, the period buffer, the interrupt, the waveform output and the error strobe are all 0.
- R2: While `run_en` is 0, the counter is held at 0. While `run_en` is 1, the counter advances by one on every cycle in which `tick` is 1, and otherwise holds.
- R3: A write with `reg_addr`=0 loads the duty threshold only when `run_en` is 0 in that cycle. While `run_en` is 1, such a write is ignored. Reading with `reg_addr`=0 returns the duty threshold.
- R4: A write with `reg_addr`=1 always loads the period buffer, and reading with `reg_addr`=1 returns the buffer. When `run_en` is 0, the same write also loads the active period.
- R5: A period match is a cycle with `run_en`=1, `tick`=1 and the counter equal to the active period. After a match edge, the counter reads 0 and `irq` is 1 for exactly that one following cycle.
- R6: On a period match, the buffered period is copied into the active period. While running, the active period changes at no other time.
- R7: If a period write coincides with a period match, the copy is skipped. The buffer takes the new value, and the active period stays unchanged until a later match.
- R8: `mode`=1 is PWM. `out` goes to 1 in the cycle after the timer is enabled and after each period match. `out` goes to 0 after a duty match (`run_en`=1, `tick`=1, counter equal to the duty threshold). If both matches occur in the same cycle, the period match wins.
- R9: `mode`=2 is carrier: `out` toggles once for each duty match and once for each period match, so two matches in the same cycle leave `out` unchanged. `mode`=0 or 3 is interval: `out` toggles on each period match. In every mode, `out` is 0 while `run_en` is 0.
- R10: A period write sets a sticky flag, and a falling edge of `run_en` clears it unless a period write occurs in that same cycle. A rising edge of `run_en` in mode 1 or 2 with the flag clear pulses `restart_err` for one cycle. A write in the enabling cycle itself comes too late to count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Count enable |
| tick | input | 1 | Count qualifier from an external prescaler |
| mode | input | 2 | 0/3 interval, 1 PWM, 2 carrier |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 duty threshold, 1 period |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| count | output | 8 | Current counter value |
| irq | output | 1 | One-cycle period-match interrupt |
| out | output | 1 | Waveform output |
| restart_err | output | 1 | Strobe for an enable without a fresh period write |

## Verification
The bench aims a period write at the exact match cycle. A design that promotes the buffer anyway would clear the counter at the new period one frame early. It also writes the duty threshold while the timer runs. A design that accepts that write would show the new value on read-back and move the PWM falling edge. Other runs re-enable the timer with and without a fresh period write, which exposes a sticky flag that is never cleared or is cleared at the wrong edge. Small compare values and a period of zero create coincident duty and period matches, where a wrong priority or a wrong double toggle shows up directly on `out`.

// File: rtl/tmrb_pkg.sv
package tmrb_pkg;
  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_PWM      = 2'd1,
    MODE_CARRIER  = 2'd2,
    MODE_ALT      = 2'd3
  } tmrb_mode_e;
endpackage

// File: rtl/tmrb_regs.sv
module tmrb_regs
  import tmrb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  tmrb_mode_e   mode,
  input  logic         reg_wr,
  input  logic         reg_addr,
  input  logic [W-1:0] reg_wdata,
  input  logic         prd_match,
  output logic [W-1:0] reg_rdata,
  output logic [W-1:0] duty_q,
  output logic [W-1:0] prd_act_q,
  output logic         start,
  output logic         restart_err
);
  logic [W-1:0] prd_buf_q;
  logic         run_q;
  logic         armed_q;
  logic         wr_duty, wr_prd, stop;

  assign wr_duty = reg_wr && !reg_addr;
  assign wr_prd  = reg_wr &&  reg_addr;
  assign start   = run_en && !run_q;
  assign stop    = !run_en && run_q;
  assign reg_rdata = reg_addr ? prd_buf_q : duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q      <= '0;
      prd_buf_q   <= '0;
      prd_act_q   <= '0;
      run_q       <= 1'b0;
      armed_q     <= 1'b0;
      restart_err <= 1'b0;
    end else begin
      run_q <= run_en;
      if (wr_duty && !run_en) duty_q <= reg_wdata;
      if (wr_prd) prd_buf_q <= reg_wdata;
      if (wr_prd && !run_en)          prd_act_q <= reg_wdata;
      else if (prd_match && !wr_prd)  prd_act_q <= prd_buf_q;
      if (wr_prd)     armed_q <= 1'b1;
      else if (stop)  armed_q <= 1'b0;
      restart_err <= start && !armed_q &&
                     (mode == MODE_PWM || mode == MODE_CARRIER);
    end
  end

  AST_DUTY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> $stable(duty_q)); // R3
  AST_ACT_KEPT_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_match && wr_prd) |=> $stable(prd_act_q)); // R7
  AST_ACT_ONLY_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !prd_match) |=> $stable(prd_act_q)); // R6
endmodule

// File: rtl/tmrb_counter.sv
module tmrb_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         tick,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] prd_act,
  output logic [W-1:0] count_q,
  output logic         duty_match,
  output logic         prd_match,
  output logic         irq_q
);
  localparam logic [W-1:0] ONE = W'(1);

  assign prd_match  = run_en && tick && (count_q == prd_act);
  assign duty_match = run_en && tick && (count_q == duty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= prd_match;
      if (!run_en)        count_q <= '0;
      else if (prd_match) count_q <= '0;
      else if (tick)      count_q <= count_q + ONE;
    end
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (count_q == '0)); // R2
  AST_CLEAR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    prd_match |=> (irq_q && count_q == '0)); // R5
endmodule

// File: rtl/tmrb_wave.sv
module tmrb_wave
  import tmrb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       start,
  input  tmrb_mode_e mode,
  input  logic       duty_match,
  input  logic       prd_match,
  output logic       out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       out_q <= 1'b0;
    else if (!run_en) out_q <= 1'b0;
    else begin
      case (mode)
        MODE_PWM: begin
          if (start || prd_match) out_q <= 1'b1;
          else if (duty_match)    out_q <= 1'b0;
        end
        MODE_CARRIER: out_q <= out_q ^ (duty_match ^ prd_match);
        default:      out_q <= out_q ^ prd_match;
      endcase
    end
  end

  AST_PWM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PWM && prd_match) |=> out_q); // R8
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !out_q); // R9
endmodule

// File: rtl/tmrb_top.sv
module tmrb_top
  import tmrb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic         reg_wr,
  input  logic         reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic [W-1:0] count,
  output logic         irq,
  output logic         out,
  output logic         restart_err
);
  tmrb_mode_e   mode_e;
  logic [W-1:0] duty, prd_act;
  logic         start, duty_match, prd_match;

  assign mode_e = tmrb_mode_e'(mode);

  tmrb_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode_e),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .prd_match(prd_match), .reg_rdata(reg_rdata), .duty_q(duty),
    .prd_act_q(prd_act), .start(start), .restart_err(restart_err)
  );

  tmrb_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
    .duty(duty), .prd_act(prd_act), .count_q(count),
    .duty_match(duty_match), .prd_match(prd_match), .irq_q(irq)
  );

  tmrb_wave u_wave (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .start(start),
    .mode(mode_e), .duty_match(duty_match), .prd_match(prd_match),
    .out_q(out)
  );
endmodule

// File: tb/tmrb_top_tb.sv
module tmrb_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0, tick = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata, count;
  logic       irq, out, restart_err;

  int errors = 0;
  int checks = 0;

  // reference state
  logic [7:0] m_cnt = 0, m_duty = 0, m_buf = 0, m_act = 0;
  logic       m_runq = 0, m_arm = 0, m_irq = 0, m_out = 0, m_err = 0;
  logic [1:0] m_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmrb_top u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .mode(mode),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count(count), .irq(irq), .out(out),
    .restart_err(restart_err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd_exp(logic a);
    return a ? m_buf : m_duty;
  endfunction

  task automatic model(logic wr, logic a, logic [7:0] d, logic run, logic tk, logic [1:0] md);
    logic pm, dm, st, wp;
    pm = run && tk && (m_cnt == m_act);
    dm = run && tk && (m_cnt == m_duty);
    st = run && !m_runq;
    wp = wr && a;
    m_err = st && !m_arm && (md == 2'd1 || md == 2'd2);
    if (!run) m_out = 1'b0;
    else if (md == 2'd1) begin
      if (st || pm) m_out = 1'b1;
      else if (dm) m_out = 1'b0;
    end else if (md == 2'd2) m_out = m_out ^ dm ^ pm;
    else m_out = m_out ^ pm;
    m_irq = pm;
    if (!run) m_cnt = 0;
    else if (pm) m_cnt = 0;
    else if (tk) m_cnt = m_cnt + 8'd1;
    if (wr && !a && !run) m_duty = d;
    if (wp && !run) m_act = d;
    else if (pm && !wp) m_act = m_buf;
    if (wp) m_buf = d;
    if (wp) m_arm = 1'b1;
    else if (!run && m_runq) m_arm = 1'b0;
    m_runq = run;
    m_mode = md;
  endtask

  task automatic step(logic wr, logic a, logic [7:0] d, logic run, logic tk, logic [1:0] md);
    @(negedge clk);
    chk("R2 count", count, m_cnt);
    chk("R5 irq", irq, m_irq);
    if (m_mode == 2'd1) chk("R8 pwm out", out, m_out);
    else chk("R9 out", out, m_out);
    chk("R10 restart_err", restart_err, m_err);
    if (reg_addr) chk("R4 read period buffer", reg_rdata, rd_exp(1'b1));
    else chk("R3 read duty", reg_rdata, rd_exp(1'b0));
    reg_wr = wr; reg_addr = a; reg_wdata = d; run_en = run; tick = tk; mode = md;
    model(wr, a, d, run, tk, md);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic run, wr, a, tk;
    logic [1:0] md;
    logic [7:0] d;
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
    chk("R1 out", out, 0);
    chk("R1 err", restart_err, 0);
    chk("R1 duty", reg_rdata, 0);
    reg_addr = 1'b1; #1;
    chk("R1 period", reg_rdata, 0);
    reg_addr = 1'b0;
    rst_n = 1'b1;

    // directed: PWM, duty 2, period 5
    step(1, 0, 8'd2, 0, 0, 2'd1);
    step(1, 1, 8'd5, 0, 0, 2'd1);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1, 2'd1);
    // R3: duty write while running must be ignored
    step(1, 0, 8'd4, 1, 1, 2'd1);
    step(0, 0, 0, 1, 1, 2'd1);
    chk("R3 duty unchanged while running", reg_rdata, 2);
    // R7: period write aimed at the match cycle
    while (m_cnt != m_act) step(0, 1, 0, 1, 1, 2'd1);
    step(1, 1, 8'd9, 1, 1, 2'd1);
    for (int i = 0; i < 30; i++) step(0, 1, 0, 1, 1, 2'd1);
    // R6: normal promotion while running
    step(1, 1, 8'd3, 1, 1, 2'd2);
    for (int i = 0; i < 30; i++) step(0, 0, 0, 1, 1, 2'd2);
    // R10: stop, restart without a fresh period write
    step(0, 0, 0, 0, 0, 2'd1);
    step(0, 0, 0, 0, 0, 2'd1);
    step(0, 0, 0, 1, 1, 2'd1);
    step(0, 0, 0, 1, 1, 2'd1);
    chk("R10 seen error expectation", m_err ? 1 : 0, 0);
    // R9: coincident matches with period 0 in carrier mode
    step(0, 0, 0, 0, 0, 2'd2);
    step(1, 1, 8'd0, 0, 0, 2'd2);
    step(1, 0, 8'd0, 0, 0, 2'd2);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 1, 2'd2);

    // constrained random phase
    run = 0; md = 2'd1;
    for (int i = 0; i < 4000; i++) begin
      wr = 0; a = 0; d = 8'($urandom % 12); tk = ($urandom % 4) != 0;
      if (($urandom % 50) == 0) begin
        run = !run;
        if (!run) md = 2'($urandom % 4);
      end
      if (($urandom % 10) == 0) begin wr = 1; a = 1'($urandom % 2); end
      if (!run && ($urandom % 3) == 0) begin wr = 1; a = 1; end
      step(wr, a, d, run, tk, md);
    end
    step(0, 0, 0, 0, 0, 2'd0);
    step(0, 0, 0, 0, 0, 2'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule